// File: doc/BRIEF.md
# Base-4 Systolic DFT Engine

This block computes a complex discrete Fourier transform over a block of `N` samples. `N` is a parameter and must be a multiple of 16. It does not have to be a power of four. Each sample carries a 16-bit signed real part and a 16-bit signed imaginary part. A one-cycle `start` pulse opens a block. The next `N` cycles with `in_valid` high deliver `x[0]` to `x[N-1]`. After a fixed compute phase the block streams the `N` frequency bins in ascending order, with `out_valid` held high.

The sample vector is viewed as four rows of `M = N/4` columns: `x[M*a + m]`. The first stage applies 4-point transforms along each column. Its weights are only +1, -1, +j and -j, so it is built from sign changes, real/imaginary swaps and adders. A row of `M` multiply-accumulate cells then handles the remaining work. One pass runs for each residue `c = k mod 4`. In each pass, cell `q` weights column `m` by the twiddle `exp(-j*2*pi*m*(4q+c)/N)` and accumulates across all `M` columns to form bin `4q+c`. The twiddles are computed from `N` at elaboration. They have 15 fraction bits and are stored in 17 bits, so +1 and -1 are exact.

Each result is divided by `2^SCALE_SH`, rounded and clamped to 16 bits.

Top module: `quad_dft_engine`

## Requirements
- R1: After reset, `out_valid` is low. It stays low until a full block has been loaded and transformed.
- R2: A `start` pulse while idle opens loading. The next `N` cycles with `in_valid` high supply `x[0]` to `x[N-1]` in arrival order. Cycles with `in_valid` low are skipped.
- R3: Each output bin equals `sum_n x[n]*exp(-j*2*pi*n*k/N) / 2^SCALE_SH`, within 2 LSB on each component.
- R4: `out_valid` stays high for exactly `N` consecutive cycles per block. It carries bins `k = 0, 1, ..., N-1` in that order, then drops.
- R5: `out_valid` rises exactly `N` clock edges after the edge that accepts the last sample of a block.
- R6: A `start` while a block is loading, computing or being output has no effect. So does `in_valid` outside loading. Neither disturbs the block in progress, and neither opens a new one.
- R7: A result beyond the 16-bit range is clamped to 32767 or to -32768.
- R8: Rounding is half-up: a result of exactly +0.5 LSB gives 1, -0.5 gives 0, +1.5 gives 2 and -1.5 gives -1. Unit twiddles carry no quantisation error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new block when the engine is idle |
| in_valid | input | 1 | Marks a sample on `in_re`/`in_im` during loading |
| in_re | input | DW | Sample real part, signed |
| in_im | input | DW | Sample imaginary part, signed |
| out_valid | output | 1 | High while a bin is presented |
| out_re | output | DW | Bin real part, signed |
| out_im | output | DW | Bin imaginary part, signed |

## Verification
A single impulse at `x[0]`, with values chosen to land exactly on half-LSB results, isolates the rounding rule from any twiddle error. A constant input near full scale puts all energy in bin 0 and drives it past the 16-bit range, which shows the clamp. A multi-tone block and two pseudo-random blocks exercise every twiddle exponent and both rotation directions of the adder stage. One of them is loaded with idle gaps, stray `start` pulses and stray samples, which separates correct gating from a design that restarts or absorbs extra data.

// File: rtl/quad_dft_engine.sv
module quad_dft_engine #(
  parameter int N        = 16,
  parameter int DW       = 16,
  parameter int SCALE_SH = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam int M   = N / 4;
  localparam int NW  = $clog2(N);
  localparam int MW  = $clog2(M);
  localparam int AW  = DW + 2;
  localparam int CW  = 17;
  localparam int PW  = AW + CW;
  localparam int SW  = PW + NW + 1;
  localparam int RSH = 15 + SCALE_SH;
  localparam real PI = 3.14159265358979323846;
  localparam logic signed [SW-1:0] RND = SW'(64'sd1 <<< (RSH - 1));
  localparam logic [1:0] S_IDLE = 2'd0, S_LOAD = 2'd1, S_COMP = 2'd2, S_OUT = 2'd3;

  function automatic logic signed [CW-1:0] q15(input real v);
    real s;
    s = v * 32768.0;
    return CW'($rtoi(s >= 0.0 ? s + 0.5 : s - 0.5));
  endfunction

  function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] hi, lo;
    hi = SW'(2 ** (DW - 1) - 1);
    lo = -hi - SW'(1);
    if (v > hi) return {1'b0, {(DW-1){1'b1}}};
    if (v < lo) return {1'b1, {(DW-1){1'b0}}};
    return v[DW-1:0];
  endfunction

  logic [1:0]          st;
  logic [NW-1:0]       cnt;
  logic [1:0]          cph;
  logic [MW-1:0]       mi;
  logic signed [DW-1:0] xr [N];
  logic signed [DW-1:0] xi [N];
  logic signed [DW-1:0] yr [N];
  logic signed [DW-1:0] yi [N];
  logic signed [CW-1:0] wre [N];
  logic signed [CW-1:0] wim [N];
  logic signed [DW-1:0] cre [M];
  logic signed [DW-1:0] cim [M];
  logic signed [AW-1:0] ar, ai;

  for (genvar e = 0; e < N; e++) begin : g_rom
    assign wre[e] = q15($cos(2.0 * PI * real'(e) / real'(N)));
    assign wim[e] = q15(-$sin(2.0 * PI * real'(e) / real'(N)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; cph <= '0; mi <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin st <= S_LOAD; cnt <= '0; end
        S_LOAD: if (in_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == NW'(N - 1)) begin st <= S_COMP; mi <= '0; cph <= '0; end
        end
        S_COMP: if (mi == MW'(M - 1)) begin
          mi  <= '0;
          cph <= cph + 1'b1;
          if (cph == 2'd3) begin st <= S_OUT; cnt <= '0; end
        end else mi <= mi + 1'b1;
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == NW'(N - 1)) st <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk)
    if (st == S_LOAD && in_valid) begin
      xr[cnt] <= in_re;
      xi[cnt] <= in_im;
    end

  always_comb begin
    logic signed [AW-1:0] vr, vi;
    ar = '0;
    ai = '0;
    for (int a = 0; a < 4; a++) begin
      vr = AW'(xr[a * M + int'(mi)]);
      vi = AW'(xi[a * M + int'(mi)]);
      case (2'(a * int'(cph)))
        2'd0: begin ar = ar + vr; ai = ai + vi; end
        2'd1: begin ar = ar + vi; ai = ai - vr; end
        2'd2: begin ar = ar - vr; ai = ai - vi; end
        default: begin ar = ar - vi; ai = ai + vr; end
      endcase
    end
  end

  for (genvar q = 0; q < M; q++) begin : g_cell
    logic [NW-1:0]        ex;
    logic signed [PW-1:0] pr, pim;
    logic signed [SW-1:0] accr, acci, tr, ti;
    assign ex  = NW'((int'(mi) * (4 * q + int'(cph))) % N);
    assign pr  = PW'(ar) * PW'(wre[ex]) - PW'(ai) * PW'(wim[ex]);
    assign pim = PW'(ar) * PW'(wim[ex]) + PW'(ai) * PW'(wre[ex]);
    assign tr  = accr + SW'(pr);
    assign ti  = acci + SW'(pim);
    assign cre[q] = clip((tr + RND) >>> RSH);
    assign cim[q] = clip((ti + RND) >>> RSH);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        accr <= '0; acci <= '0;
      end else if (st == S_COMP) begin
        accr <= (mi == MW'(M - 1)) ? '0 : tr;
        acci <= (mi == MW'(M - 1)) ? '0 : ti;
      end
  end

  always_ff @(posedge clk)
    if (st == S_COMP && mi == MW'(M - 1))
      for (int q = 0; q < M; q++) begin
        yr[4 * q + int'(cph)] <= cre[q];
        yi[4 * q + int'(cph)] <= cim[q];
      end

  assign out_valid = (st == S_OUT);
  assign out_re    = yr[cnt];
  assign out_im    = yi[cnt];
endmodule

// File: rtl/quad_dft_engine_chk.sv
module quad_dft_engine_chk #(
  parameter int N = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       in_valid,
  input logic       out_valid,
  input logic [1:0] st
);
  logic [15:0] run;
  logic [15:0] since;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= '0; since <= '0;
    end else begin
      run   <= out_valid ? run + 16'd1 : 16'd0;
      since <= (st == 2'd1 && in_valid) ? 16'd1 : (since == 16'hffff ? since : since + 16'd1);
    end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> !out_valid);                                      // R1
  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && !in_valid) |=> st == 2'd1);                        // R2
  AST_BURST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> run == 16'(N));                               // R4
  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> run < 16'(N));                                       // R4
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> since == 16'(N + 1));                         // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st[1]) |=> st != 2'd1);                                 // R6
endmodule

bind quad_dft_engine quad_dft_engine_chk #(.N(N)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .out_valid(out_valid), .st(st)
);

// File: tb/quad_dft_engine_test.sv
`timescale 1ns/1ps
module quad_dft_engine_test;
  localparam int N  = 16;
  localparam int SH = 2;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic signed [15:0] out_re, out_im;
  int errors = 0, checks = 0;
  int xr [N];
  int xi [N];

  always #2.5 clk = ~clk;

  quad_dft_engine #(.N(N), .DW(16), .SCALE_SH(SH)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
    .out_re(out_re), .out_im(out_im)
  );

  task automatic check(string req, string what, int got, int exp, int tol);
    checks++;
    if (got - exp > tol || exp - got > tol) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  function automatic int ref_bin(int k, bit imag);
    real sr, si, ang, v;
    sr = 0.0; si = 0.0;
    for (int n = 0; n < N; n++) begin
      ang = 2.0 * PI * real'(n * k) / real'(N);
      sr += real'(xr[n]) * $cos(ang) + real'(xi[n]) * $sin(ang);
      si += real'(xi[n]) * $cos(ang) - real'(xr[n]) * $sin(ang);
    end
    v = $floor((imag ? si : sr) / real'(1 << SH) + 0.5);
    if (v > 32767.0) v = 32767.0;
    if (v < -32768.0) v = -32768.0;
    return $rtoi(v);
  endfunction

  task automatic run_block(string req, int tol, bit gaps, bit noise);
    int lat;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int n = 0; n < N; n++) begin
      if (gaps && n % 3 == 1) begin
        in_valid = 1'b0; in_re = 16'sh7abc; in_im = -16'sd1;
        @(negedge clk);
      end
      in_valid = 1'b1; in_re = 16'(xr[n]); in_im = 16'(xi[n]);
      start = noise && n == 5;   // R6: start during loading
      @(negedge clk);
    end
    in_valid = 1'b0; start = 1'b0;
    lat = 0;
    while (!out_valid && lat < 4 * N) begin
      start    = noise && lat == 2;   // R6: start and stray sample while computing
      in_valid = noise && lat == 2;
      in_re    = 16'sd12345;
      @(negedge clk);
      lat++;
    end
    start = 1'b0; in_valid = 1'b0;
    check("R5", "latency edges", lat, N, 0);
    for (int k = 0; k < N; k++) begin
      check("R4", $sformatf("out_valid at bin %0d", k), int'(out_valid), 1, 0);
      check(req, $sformatf("re[%0d]", k), int'(out_re), ref_bin(k, 1'b0), tol);
      check(req, $sformatf("im[%0d]", k), int'(out_im), ref_bin(k, 1'b1), tol);
      start = noise && k == 3;   // R6: start during output
      @(negedge clk);
    end
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R4", "out_valid low after burst", int'(out_valid), 0, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    in_valid = 1'b1; in_re = 16'sd999;
    repeat (3) begin
      @(negedge clk);
      check("R1", "out_valid in reset", int'(out_valid), 0, 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      in_valid = (i % 2 == 0); in_re = 16'(i * 77); in_im = 16'(-i);
      @(negedge clk);
      check("R1", "out_valid without start", int'(out_valid), 0, 0);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_round;
    for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 2; xi[0] = -6;   // R8: +0.5 -> 1, -1.5 -> -1
    run_block("R8", 0, 1'b0, 1'b0);
    xr[0] = 6; xi[0] = -2;   // R8: +1.5 -> 2, -0.5 -> 0
    run_block("R8", 0, 1'b0, 1'b0);
  endtask

  task automatic t_tones;
    for (int n = 0; n < N; n++) begin
      xr[n] = $rtoi(3000.0 * $cos(2.0 * PI * 3.0 * n / N) + 1500.0 * $sin(2.0 * PI * 6.0 * n / N));
      xi[n] = $rtoi(2000.0 * $sin(2.0 * PI * 1.0 * n / N) - 700.0);
    end
    run_block("R3", 2, 1'b0, 1'b0);
  endtask

  task automatic t_random(int seed, bit stress);
    int s = seed;
    for (int n = 0; n < N; n++) begin
      s = s * 1103515245 + 12345;
      xr[n] = ((s >>> 8) % 8000);
      s = s * 1103515245 + 12345;
      xi[n] = ((s >>> 8) % 8000);
    end
    if (stress) run_block("R3,R2,R6", 2, 1'b1, 1'b1);
    else        run_block("R3", 2, 1'b0, 1'b0);
  endtask

  task automatic t_saturate;
    for (int n = 0; n < N; n++) begin xr[n] = 10000; xi[n] = -10000; end
    run_block("R7", 1, 1'b0, 1'b0);
    check("R7", "reference bin0 re clamps", ref_bin(0, 1'b0), 32767, 0);
    check("R7", "reference bin0 im clamps", ref_bin(0, 1'b1), -32768, 0);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_round();
    t_tones();
    t_random(7, 1'b1);
    t_saturate();
    t_random(4242, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule